// File: doc/BRIEF.md
# Guarded Power-Down Entry Controller

This block holds a byte-wide power-control register and decides when the chip may stop its clocks. Stopping the clocks by accident would freeze the chip, so entry takes two writes in a row. The first write sets an arm bit while leaving a start bit clear. The write that comes straight after it must set the start bit while leaving the arm bit clear. Neither bit is ever stored, and both always read back as zero. All the other bits of the register are plain storage.

Once power-down is entered, the block drops the enables for the RC oscillator, the crystal oscillator and the PLL. It asks the bus to hold the address-latch strobe and the program-store strobe low, and it raises a status flag. Register writes are ignored while the block is down. There are two ways out. A reset returns everything to its reset state. A wake exit happens when wake-up is enabled and either of two active-low wake pins is seen low after a two-flop synchronizer; the clocks restart and the register keeps its contents.

Top module: `pdn_guard_ctrl`

## Requirements
- R1: A write to the register address with bit 1 set and bit 6 clear arms the block. Arming on its own does not change any output.
- R2: When the block is armed and the next write goes to the register with bit 6 set and bit 1 clear, `pdn_active` is high from the cycle after that write. A start write that is not armed has no effect.
- R3: A write with bit 1 and bit 6 both set does not enter power-down and does not arm the block.
- R4: Any write between the arm write and the start write cancels the armed state. This covers a write to another address and a write to the register with other data. A start write after such a write is ignored.
- R5: Reading the register always returns 0 in bits 1 and 6. Reading any other address returns 0.
- R6: While `pdn_active` is high, `rc_osc_en`, `xtal_osc_en` and `pll_en` are low, and `ale_hold_low` and `psen_hold_low` are high. Outside power-down the enables are high and the hold outputs are low.
- R7: With `wake_en` high, a low level on `wake_a_n` or `wake_b_n` clears `pdn_active` on the third rising edge after the pin falls, because of the two-flop synchronizer. The clock enables return and the stored register bits are kept.
- R8: With `wake_en` low, the wake pins have no effect and the block stays in power-down.
- R9: Asserting `rst_n` low ends power-down and returns the register to its reset value of 0x00.
- R10: Bits other than 1 and 6 take the written value on a register write made outside power-down. Register writes made during power-down are ignored.
- R11: If a wake pin is already low when the start write occurs and `wake_en` is high, `pdn_active` is high for exactly one cycle and then clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data, combinational |
| wake_a_n | input | 1 | First wake pin, active low, asynchronous |
| wake_b_n | input | 1 | Second wake pin, active low, asynchronous |
| wake_en | input | 1 | Lets the wake pins end power-down |
| rc_osc_en | output | 1 | RC oscillator enable |
| xtal_osc_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |
| pdn_active | output | 1 | Power-down status |
| ale_hold_low | output | 1 | Request to hold the address-latch strobe low |
| psen_hold_low | output | 1 | Request to hold the program-store strobe low |

## Verification
The bench tries the sequences that are most likely to be gotten wrong.

- **Both bits in one write.** A design that ORs the two bits into a sticky flag would enter power-down from the 0x42 write followed by a start write.
- **An intervening write.** A design that only watches register writes would miss a write to another address placed between the arm and start writes, and would enter power-down when it should not.
- **Wake timing and gating.** The wake exit is timed edge by edge. This catches a synchronizer that is one flop short or one flop long, and a wake path that ignores `wake_en`.
- **A wake pin already low at entry.** This must give a one-cycle power-down, which shows that the wake path is gated by the power-down state and not triggered by an edge.

The bench also checks that bits 1 and 6 read back as zero and that writes made during power-down leave the stored bits alone.

// File: rtl/pdn_guard_pkg.sv
package pdn_guard_pkg;

   typedef enum logic [1:0] {
      PD_RUN   = 2'd0,
      PD_ARMED = 2'd1,
      PD_DOWN  = 2'd2
   } pd_state_e;

   function automatic logic [31:0] bit_mask32(input int unsigned pos);
      return 32'd1 << pos;
   endfunction

endpackage

// File: rtl/pdn_wake_sync.sv
module pdn_wake_sync #(
   parameter int LANES  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] pin_n,
   output logic             wake_o
);

   localparam int LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pdn_wake_sync: STAGES must be at least 2");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("pdn_wake_sync: LANES must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][LANES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '1;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], pin_n};
      end
   end

   logic [LANES-1:0] lane_low;

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         assign lane_low[l] = ~chain_q[LAST][l];
      end
   endgenerate

   assign wake_o = |lane_low;

endmodule

// File: rtl/pdn_store_reg.sv
module pdn_store_reg #(
   parameter int                 DATA_W    = 8,
   parameter int                 ARM_BIT   = 1,
   parameter int                 START_BIT = 6,
   parameter logic [DATA_W-1:0]  RESET_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              frozen,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] q_o
);

   localparam logic [DATA_W-1:0] ONE       = DATA_W'(1);
   localparam logic [DATA_W-1:0] CTRL_MASK = (ONE << ARM_BIT) | (ONE << START_BIT);
   localparam logic [DATA_W-1:0] KEEP_MASK = ~CTRL_MASK;
   localparam logic [DATA_W-1:0] INIT_VAL  = RESET_VAL & KEEP_MASK;

   logic [DATA_W-1:0] store_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         store_q <= INIT_VAL;
      end else if (reg_wr && !frozen) begin
         store_q <= wr_data & KEEP_MASK;
      end
   end

   assign q_o = store_q;

   // R10: no write reaches storage while the clocks are stopped.
   assert_frozen_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
      frozen |=> $stable(q_o));

endmodule

// File: rtl/pdn_entry_fsm.sv
module pdn_entry_fsm
   import pdn_guard_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int ARM_BIT   = 1,
   parameter int START_BIT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              any_wr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wake_req,
   input  logic              wake_en,
   output logic              pd_o
);

   pd_state_e state_q, state_d;
   logic      arm_pat, start_pat;

   assign arm_pat   = wr_data[ARM_BIT] & ~wr_data[START_BIT];
   assign start_pat = wr_data[START_BIT] & ~wr_data[ARM_BIT];

   always_comb begin
      state_d = state_q;
      case (state_q)
         PD_RUN: begin
            if (reg_wr && arm_pat) state_d = PD_ARMED;
         end
         PD_ARMED: begin
            if (any_wr) begin
               if (reg_wr && start_pat)    state_d = PD_DOWN;
               else if (reg_wr && arm_pat) state_d = PD_ARMED;
               else                        state_d = PD_RUN;
            end
         end
         PD_DOWN: begin
            if (wake_en && wake_req) state_d = PD_RUN;
         end
         default: state_d = PD_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PD_RUN;
      else        state_q <= state_d;
   end

   assign pd_o = (state_q == PD_DOWN);

   // R2: power-down is only ever entered out of the armed state.
   assert_arm_before_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pd_o) |-> $past(state_q) == PD_ARMED);

   // R3: a write carrying both control bits never stops the clocks.
   assert_dual_set_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && wr_data[ARM_BIT] && wr_data[START_BIT] && !pd_o) |=> !pd_o);

   // R4: an intervening write drops the armed state.
   assert_cancel_on_other_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PD_ARMED && any_wr && !(reg_wr && start_pat)) |=> !pd_o);

   // R8: with wake-up disabled, power-down persists.
   assert_hold_without_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_o && !wake_en) |=> pd_o);

endmodule

// File: rtl/pdn_guard_ctrl.sv
module pdn_guard_ctrl #(
   parameter int                ADDR_W     = 8,
   parameter int                DATA_W     = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR   = 8'h87,
   parameter int                ARM_BIT    = 1,
   parameter int                START_BIT  = 6,
   parameter logic [DATA_W-1:0] RESET_VAL  = '0,
   parameter int                SYNC_DEPTH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wake_a_n,
   input  logic              wake_b_n,
   input  logic              wake_en,
   output logic              rc_osc_en,
   output logic              xtal_osc_en,
   output logic              pll_en,
   output logic              pdn_active,
   output logic              ale_hold_low,
   output logic              psen_hold_low
);

   localparam int WAKE_LANES = 2;

   generate
      if (ARM_BIT == START_BIT) begin : g_bad_bits
         $error("pdn_guard_ctrl: ARM_BIT and START_BIT must differ");
      end
      if (ARM_BIT >= DATA_W || START_BIT >= DATA_W) begin : g_bad_pos
         $error("pdn_guard_ctrl: control bit outside the data width");
      end
      if (SYNC_DEPTH < 2) begin : g_bad_sync
         $error("pdn_guard_ctrl: SYNC_DEPTH must be at least 2");
      end
   endgenerate

   logic              reg_wr;
   logic              wake_req;
   logic              pd;
   logic [DATA_W-1:0] store;

   assign reg_wr = wr_en && (wr_addr == REG_ADDR);

   pdn_wake_sync #(
      .LANES (WAKE_LANES),
      .STAGES(SYNC_DEPTH)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_n ({wake_b_n, wake_a_n}),
      .wake_o(wake_req)
   );

   pdn_entry_fsm #(
      .DATA_W   (DATA_W),
      .ARM_BIT  (ARM_BIT),
      .START_BIT(START_BIT)
   ) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .reg_wr  (reg_wr),
      .any_wr  (wr_en),
      .wr_data (wr_data),
      .wake_req(wake_req),
      .wake_en (wake_en),
      .pd_o    (pd)
   );

   pdn_store_reg #(
      .DATA_W   (DATA_W),
      .ARM_BIT  (ARM_BIT),
      .START_BIT(START_BIT),
      .RESET_VAL(RESET_VAL)
   ) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .reg_wr (reg_wr),
      .frozen (pd),
      .wr_data(wr_data),
      .q_o    (store)
   );

   assign rd_data       = (rd_addr == REG_ADDR) ? store : '0;
   assign pdn_active    = pd;
   assign rc_osc_en     = ~pd;
   assign xtal_osc_en   = ~pd;
   assign pll_en        = ~pd;
   assign ale_hold_low  = pd;
   assign psen_hold_low = pd;

   // R7: a wake exit keeps the stored bits unchanged across the transition.
   assert_wake_keeps_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pdn_active) |-> $stable(store));

endmodule

// File: tb/pdn_guard_ctrl_test.sv
`timescale 1ns/1ps
module pdn_guard_ctrl_test;

   localparam logic [7:0] REG_A   = 8'h87;
   localparam logic [7:0] OTHER_A = 8'h20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       wake_a_n = 1'b1;
   logic       wake_b_n = 1'b1;
   logic       wake_en = 1'b0;
   logic       rc_osc_en, xtal_osc_en, pll_en, pdn_active, ale_hold_low, psen_hold_low;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   pdn_guard_ctrl uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .wake_a_n(wake_a_n), .wake_b_n(wake_b_n),
      .wake_en(wake_en), .rc_osc_en(rc_osc_en), .xtal_osc_en(xtal_osc_en), .pll_en(pll_en),
      .pdn_active(pdn_active), .ale_hold_low(ale_hold_low), .psen_hold_low(psen_hold_low)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
      rd_addr = a;
      #1;
      check(rd_data == exp, req, rd_data, exp);
   endtask

   task automatic chk_pd(input bit exp, input string req);
      check(pdn_active == exp, req, pdn_active, exp);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      cyc(2);
      rst_n = 1'b1;
      cyc(1);
   endtask

   task automatic t_reset_state();
      do_reset();
      chk_pd(1'b0, "R9 reset pd");
      check({rc_osc_en, xtal_osc_en, pll_en, ale_hold_low, psen_hold_low} == 5'b11100,
            "R6 run outputs", {rc_osc_en, xtal_osc_en, pll_en, ale_hold_low, psen_hold_low}, 5'b11100);
      rd_chk(REG_A, 8'h00, "R9 reset value");
   endtask

   task automatic t_storage();
      wr(REG_A, 8'hFF);
      rd_chk(REG_A, 8'hBD, "R5 ctrl bits read zero");
      wr(REG_A, 8'h81);
      rd_chk(REG_A, 8'h81, "R10 plain storage");
      rd_chk(OTHER_A, 8'h00, "R5 other address reads zero");
      chk_pd(1'b0, "R1 no pd from storage writes");
   endtask

   task automatic t_dual_set();
      do_reset();
      wr(REG_A, 8'h42);
      chk_pd(1'b0, "R3 dual set no entry");
      wr(REG_A, 8'h40);
      chk_pd(1'b0, "R3 dual set does not arm");
   endtask

   task automatic t_start_alone();
      do_reset();
      wr(REG_A, 8'h40);
      cyc(1);
      chk_pd(1'b0, "R2 start without arm");
   endtask

   task automatic t_cancel();
      do_reset();
      wr(REG_A, 8'h02);
      chk_pd(1'b0, "R1 arm alone no change");
      wr(OTHER_A, 8'h40);
      wr(REG_A, 8'h40);
      chk_pd(1'b0, "R4 other-address write cancels");
      wr(REG_A, 8'h02);
      wr(REG_A, 8'h10);
      wr(REG_A, 8'h40);
      chk_pd(1'b0, "R4 other-data write cancels");
   endtask

   task automatic t_enter_wake();
      do_reset();
      wake_en = 1'b1;
      wr(REG_A, 8'h32);
      wr(REG_A, 8'h70);
      chk_pd(1'b1, "R2 entry after sequence");
      check({rc_osc_en, xtal_osc_en, pll_en, ale_hold_low, psen_hold_low} == 5'b00011,
            "R6 pd outputs", {rc_osc_en, xtal_osc_en, pll_en, ale_hold_low, psen_hold_low}, 5'b00011);
      rd_chk(REG_A, 8'h30, "R5 start/arm not stored");
      wr(REG_A, 8'h05);
      rd_chk(REG_A, 8'h30, "R10 write in pd ignored");
      chk_pd(1'b1, "R10 write in pd keeps pd");
      @(negedge clk);
      wake_a_n = 1'b0;
      cyc(2);
      chk_pd(1'b1, "R7 sync latency not early");
      cyc(1);
      chk_pd(1'b0, "R7 wake on third edge");
      check(rc_osc_en && xtal_osc_en && pll_en, "R7 clocks restart", {rc_osc_en, xtal_osc_en, pll_en}, 3'b111);
      rd_chk(REG_A, 8'h30, "R7 store preserved");
      wake_a_n = 1'b1;
      cyc(3);
   endtask

   task automatic t_wake_disabled();
      do_reset();
      wake_en = 1'b0;
      wr(REG_A, 8'h02);
      wr(REG_A, 8'h40);
      wake_b_n = 1'b0;
      cyc(10);
      chk_pd(1'b1, "R8 pins ignored when disabled");
      wake_en = 1'b1;
      cyc(1);
      chk_pd(1'b0, "R7 wake once enabled");
      wake_b_n = 1'b1;
      cyc(3);
   endtask

   task automatic t_reset_exit();
      do_reset();
      wake_en = 1'b0;
      wr(REG_A, 8'h32);
      wr(REG_A, 8'h70);
      chk_pd(1'b1, "R2 entry before reset");
      do_reset();
      chk_pd(1'b0, "R9 reset exits pd");
      rd_chk(REG_A, 8'h00, "R9 reset clears store");
   endtask

   task automatic t_pin_low_entry();
      do_reset();
      wake_en = 1'b1;
      wake_b_n = 1'b0;
      cyc(5);
      wr(REG_A, 8'h02);
      wr(REG_A, 8'h40);
      chk_pd(1'b1, "R11 entry with pin low");
      cyc(1);
      chk_pd(1'b0, "R11 one-cycle pd");
      wake_b_n = 1'b1;
      cyc(3);
   endtask

   initial begin
      cyc(2);
      rst_n = 1'b1;
      t_reset_state();
      t_storage();
      t_dual_set();
      t_start_alone();
      t_cancel();
      t_enter_wake();
      t_wake_disabled();
      t_reset_exit();
      t_pin_low_entry();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule